// File: doc/BRIEF.md
# Conditional jump evaluator

This block resolves branch instructions of the relative-jump format for a 16-bit processor core. Each cycle in which `valid_i` is high, it takes one instruction word, the program counter that already points past that instruction, and the four status flags. It decides whether the branch is taken and produces the program counter from which fetch continues.

The instruction word carries a 3-bit format tag in bits 15:13 (value 001 marks a jump), a 3-bit condition code in bits 12:10 and a signed 10-bit word offset in bits 9:0. A taken branch lands at the incremented PC plus twice the sign-extended offset. The flags are only read. They come back out of the register stage unchanged, so the surrounding pipeline can take them from here without a separate path. All results are registered and appear one cycle after the request.

Top module: `jmp_eval`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first request, `valid_o`, `taken_o`, `next_pc_o` and `flags_o` are all zero.
- R2: `valid_o` is high exactly in the cycle after `valid_i` is high. In a cycle after `valid_i` is low, `taken_o`, `next_pc_o` and `flags_o` keep their previous values.
- R3: For a jump, condition 000 is taken when Z=0, 001 when Z=1, 010 when C=0 and 011 when C=1.
- R4: For a jump, condition 100 is taken when N=1, 101 when N equals V, 110 when N differs from V, and 111 always.
- R5: When taken, `next_pc_o` equals `pc_i` plus twice the sign-extended `instr_i[9:0]`, modulo 2^16, with bit 0 forced to zero.
- R6: When not taken, `next_pc_o` equals `pc_i`.
- R7: A word whose bits 15:13 are not 001 is never taken, whatever its condition field and the flags.
- R8: `flags_o` is {N,Z,C,V} in bits 3..0, equal to the flags presented with the request. The block never alters them.
- R9: Offset 0x1FF adds +1022 bytes and offset 0x200 adds -1024 bytes. Targets wrap across address zero and address 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter already past the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Program counter to fetch from next |
| flags_o | output | 4 | Flags passed through as {N,Z,C,V} |

## Verification
Every condition code is tried against all sixteen flag combinations. This separates the codes that read a single flag from the signed codes that compare N against V, and it shows that the untaken path returns the incoming PC. All 1024 offsets are swept with the unconditional code over a moving PC. This covers sign extension, byte scaling and wrap-around at both ends of the address space. Words with other format tags are also applied to show that they are never taken, and idle cycles carrying junk inputs are applied to show that the registered outputs hold.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned COND_W  = 3;
  localparam int unsigned OFF_W   = 10;
  localparam int unsigned TAG_LSB = 13;
  localparam logic [2:0]  TAG_JUMP = 3'b001;

  typedef enum logic [COND_W-1:0] {
    C_NZ  = 3'b000,
    C_Z   = 3'b001,
    C_NC  = 3'b010,
    C_C   = 3'b011,
    C_NEG = 3'b100,
    C_GE  = 3'b101,
    C_LT  = 3'b110,
    C_AL  = 3'b111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
  import jmp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  flags_t             flags_i,
  output logic               taken_o
);
  cond_e cond;
  logic  is_jump;
  logic  hit;

  assign cond    = cond_e'(instr_i[TAG_LSB-1 -: COND_W]);
  assign is_jump = (instr_i[INSTR_W-1:TAG_LSB] == TAG_JUMP);

  always_comb begin
    unique case (cond)
      C_NZ:    hit = ~flags_i.z;
      C_Z:     hit =  flags_i.z;
      C_NC:    hit = ~flags_i.c;
      C_C:     hit =  flags_i.c;
      C_NEG:   hit =  flags_i.n;
      C_GE:    hit = ~(flags_i.n ^ flags_i.v);
      C_LT:    hit =  (flags_i.n ^ flags_i.v);
      default: hit = 1'b1;
    endcase
  end

  assign taken_o = is_jump & hit;
endmodule

// File: rtl/jmp_target_calc.sv
module jmp_target_calc #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 10
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W - 1;

  logic [ADDR_W-1:0] byte_off;
  logic [ADDR_W-1:0] sum;

  // word offset -> byte offset, sign extended
  assign byte_off = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
  assign sum      = pc_i + byte_off;
  assign target_o = {sum[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/jmp_eval.sv
module jmp_eval
  import jmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic                 flag_n_i,
  input  logic                 flag_z_i,
  input  logic                 flag_c_i,
  input  logic                 flag_v_i,
  output logic                 valid_o,
  output logic                 taken_o,
  output logic [ADDR_W-1:0]    next_pc_o,
  output logic [3:0]           flags_o
);
  flags_t            flags;
  logic              taken_d;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] next_pc_d;

  assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

  jmp_cond_eval u_cond (
    .instr_i (instr_i),
    .flags_i (flags),
    .taken_o (taken_d)
  );

  jmp_target_calc #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_target (
    .pc_i     (pc_i),
    .off_i    (instr_i[OFF_W-1:0]),
    .target_o (target)
  );

  assign next_pc_d = taken_d ? target : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      flags_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= taken_d;
        next_pc_o <= next_pc_d;
        flags_o   <= flags;
      end
    end
  end
endmodule

// File: rtl/jmp_eval_chk.sv
module jmp_eval_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [15:0]       instr_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              flag_n_i,
  input logic              flag_z_i,
  input logic              flag_c_i,
  input logic              flag_v_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic [3:0]        flags_o
);
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(taken_o) && $stable(next_pc_o) && $stable(flags_o)));

  a_r4_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:10] == 6'b001111) |=> taken_o);

  a_r5_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o) |-> !next_pc_o[0]);

  a_r7_not_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:13] != 3'b001) |=> (!taken_o && next_pc_o == $past(pc_i)));

  a_r8_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o == $past({flag_n_i, flag_z_i, flag_c_i, flag_v_i}));
endmodule

bind jmp_eval jmp_eval_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .pc_i      (pc_i),
  .flag_n_i  (flag_n_i),
  .flag_z_i  (flag_z_i),
  .flag_c_i  (flag_c_i),
  .flag_v_i  (flag_v_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o),
  .flags_o   (flags_o)
);

// File: tb/tb_jmp_eval.sv
module tb_jmp_eval;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] pc_i = '0;
  logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_c_i = 1'b0, flag_v_i = 1'b0;
  logic        valid_o, taken_o;
  logic [15:0] next_pc_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  jmp_eval dut (
    .clk_i, .rst_ni, .valid_i, .instr_i, .pc_i,
    .flag_n_i, .flag_z_i, .flag_c_i, .flag_v_i,
    .valid_o, .taken_o, .next_pc_o, .flags_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [15:0] w, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    if (w[15:13] != 3'b001) return 0;
    case (w[12:10])
      3'd0: return z == 0;
      3'd1: return z == 1;
      3'd2: return c == 0;
      3'd3: return c == 1;
      3'd4: return n == 1;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1;
    endcase
  endfunction

  function automatic logic [15:0] exp_target(input logic [15:0] pc, input logic [9:0] off);
    int s = (off >= 10'd512) ? int'(off) - 1024 : int'(off);
    int t = (int'(pc) + 2 * s) & 32'hFFFF;
    return 16'(t & 32'hFFFE);
  endfunction

  // Applies one request and checks the registered result one edge later.
  task automatic run(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f,
                     input string req);
    logic [15:0] exp_pc;
    bit          tk;
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = w; pc_i = pc;
    {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = f;
    tk = exp_taken(w, f);
    exp_pc = tk ? exp_target(pc, w[9:0]) : pc;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " R2 valid"}, int'(valid_o), 1);
    chk({req, " taken"}, int'(taken_o), int'(tk));
    chk({req, tk ? " R5 target" : " R6 fallthrough"}, int'(next_pc_o), int'(exp_pc));
    chk("R8 flags", int'(flags_o), int'(f));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pc;
    logic [15:0] hold_pc;
    bit          hold_tk;
    #1;
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset taken", int'(taken_o), 0);
    chk("R1 reset pc", int'(next_pc_o), 0);
    chk("R1 reset flags", int'(flags_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", int'(valid_o), 0);
    chk("R1 idle pc", int'(next_pc_o), 0);

    // Example words: JC -0x1C words, JMP -0x1D words
    run(16'h2FE4, 16'h0100, 4'b0010, "R3 jc example");
    chk("R3 jc target", int'(next_pc_o), 16'h0100 - 16'h38);
    run(16'h2FE4, 16'h0100, 4'b0000, "R3 jc example clear");
    run(16'h3FE3, 16'h0100, 4'b0000, "R4 jmp example");
    chk("R4 jmp target", int'(next_pc_o), 16'h0100 - 16'h3A);

    // All conditions x all flag combinations
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f++) begin
        run(16'h2000 | 16'(cc << 10) | 16'h0015, 16'(16'h4000 + f * 2 + cc * 64), 4'(f),
            cc < 4 ? "R3 cond" : "R4 cond");
      end
    end

    // Full offset sweep, unconditional, moving pc
    pc = 16'hFF80;
    for (int o = 0; o < 1024; o++) begin
      run(16'h3C00 | 16'(o), pc, 4'(o), "R5 offset");
      pc = pc + 16'h0102;
    end

    // Extremes and wrap
    run(16'h3DFF, 16'h1000, 4'h0, "R9 max fwd");
    chk("R9 +1022", int'(next_pc_o), 16'h1000 + 16'd1022);
    run(16'h3E00, 16'h1000, 4'h0, "R9 max back");
    chk("R9 -1024", int'(next_pc_o), 16'h1000 - 16'd1024);
    run(16'h3C10, 16'hFFF0, 4'h0, "R9 wrap high");
    chk("R9 wrap high", int'(next_pc_o), 16'h0010);
    run(16'h3FF0, 16'h0008, 4'h0, "R9 wrap low");
    chk("R9 wrap low", int'(next_pc_o), 16'hFFE8);
    run(16'h3C01, 16'h1001, 4'h0, "R5 odd pc");
    chk("R5 bit0 cleared", int'(next_pc_o), 16'h1002);

    // Other format tags never taken
    for (int t = 0; t < 8; t++) begin
      if (t == 1) continue;
      for (int f = 0; f < 16; f += 5)
        run(16'(t << 13) | 16'h1C07, 16'h2222, 4'(f), "R7 non-jump");
    end

    // Hold when idle: junk inputs with valid low
    run(16'h3C05, 16'h0200, 4'b1010, "R2 setup");
    hold_pc = next_pc_o; hold_tk = taken_o;
    @(negedge clk_i);
    valid_i = 1'b0; instr_i = 16'h2000; pc_i = 16'hABCD;
    {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = 4'b0101;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R2 idle valid low", int'(valid_o), 0);
    chk("R2 hold pc", int'(next_pc_o), int'(hold_pc));
    chk("R2 hold taken", int'(taken_o), int'(hold_tk));
    chk("R2 hold flags", int'(flags_o), 4'b1010);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule